// File: doc/BRIEF.md
# Virtual Machine Segment Quota Controller

This block holds the segment quota state that a memory-isolation unit needs while virtual machines come and go. Physical memory is split into equal segments. At boot the controller derives how many segments exist, registers the hypervisor as the one active domain, and works out how many segments each domain may hold. After that it serves two events: a launch, which admits a new domain and hands it a fresh nonzero guest ID, and a halt, which retires a domain.

A halt is more than a count change. The controller walks its segment ownership table from the lowest segment to the highest. It zero-fills every word of each segment the retiring domain owned, writing one word per cycle on a memory write port, and then returns the table entry to owner 0. Each time the active count changes, the per-domain maximum is recomputed with a bit-serial divider. While a search, sweep or division is in progress, `busy` is high and new events are ignored. The ownership check on memory accesses and the address translation buffers are handled elsewhere. Other logic fills the ownership table through an assignment port.

Top module: `vm_quota_ctrl`

## Requirements
- R1: Out of reset every count and quota output reads 0, and launch and halt requests are ignored until `boot` is pulsed. A boot pulse sets `seg_limit` to MEM_WORDS/SEG_WORDS (16 by default) and `tot` to 1. `seg_limit` keeps that value afterwards, and any later boot pulse has no effect.
- R2: An accepted launch raises `launch_ack` for one cycle and increments `tot` by one. The `new_gid` presented with it is nonzero and differs from every guest ID that is still active.
- R3: An accepted halt raises `halt_done` for one cycle once its sweep ends, and decrements `tot` by one.
- R4: After boot, launch or halt, `busy` stays high until `seg_max` equals floor(`seg_limit` / `tot`), and drops in the same cycle that this value appears.
- R5: While `busy` is high, `launch_req`, `halt_req` and `asg_en` are ignored.
- R6: On an accepted halt, each segment s owned by `halt_id` receives SEG_WORDS writes with `mem_we` high, at addresses s*SEG_WORDS+0 up to s*SEG_WORDS+SEG_WORDS-1. Consecutive write cycles step the address by one, and `mem_wdata` is zero. The segment's owner entry is then 0, and segments owned by other IDs are neither written nor changed.
- R7: A halt whose `halt_id` is 0, whose `halt_id` is not an active guest ID, or that arrives while `tot` is 1 is refused. It gives a one-cycle `halt_err`, and `tot`, the table and memory are left as they were.
- R8: A launch that arrives while `tot` equals MAX_ACTIVE (8 by default) is refused. It gives a one-cycle `launch_err`, and `tot` is left as it was.
- R9: When not busy, `asg_en` writes `asg_id` into the owner entry of segment `asg_seg`. `rd_owner` always shows the owner entry of segment `rd_seg`.
- R10: If `launch_req` and `halt_req` are both high in the same idle cycle, only the launch is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot | input | 1 | Hypervisor-loaded pulse |
| launch_req | input | 1 | Request to admit a new domain |
| halt_req | input | 1 | Request to retire a domain |
| halt_id | input | 6 | Guest ID to retire |
| asg_en | input | 1 | Ownership table write strobe |
| asg_seg | input | 4 | Segment index to assign |
| asg_id | input | 6 | Owner ID to store |
| rd_seg | input | 4 | Segment index to read |
| rd_owner | output | 6 | Owner of segment rd_seg |
| seg_limit | output | 5 | Total segment count |
| tot | output | 5 | Active domain count |
| seg_max | output | 5 | Per-domain segment maximum |
| busy | output | 1 | Search, sweep or division in progress |
| launch_ack | output | 1 | Launch accepted pulse |
| new_gid | output | 6 | Guest ID granted by the last launch |
| launch_err | output | 1 | Launch refused pulse |
| halt_done | output | 1 | Halt sweep finished pulse |
| halt_err | output | 1 | Halt refused pulse |
| mem_we | output | 1 | Zero-fill write strobe |
| mem_addr | output | 8 | Zero-fill word address |
| mem_wdata | output | 32 | Zero-fill data |

## Verification
Several properties are checked on every cycle. `tot` moves by exactly one on each acknowledge and never moves on a refusal. The quota matches floor(`seg_limit`/`tot`) at the moment `busy` falls. Zero-fill writes occur only while busy, and consecutive writes step through addresses one at a time. `seg_limit` never changes once it is set. Other behaviour can only be shown by the bench scenarios: that the writes land exactly on the segments the retiring ID owned, that owner entries are cleared, that guest IDs stay distinct across many launches and reuse, that requests arriving during busy are really dropped, and how a launch and a halt arriving together are resolved.

// File: rtl/vmq_pkg.sv
package vmq_pkg;
  localparam int ID_W = 6;

  typedef enum logic [2:0] {ST_OFF, ST_IDLE, ST_GID, ST_SWEEP, ST_DIV} ctl_state_e;

  // maximal-length 6-bit shift sequence, never reaches zero from a nonzero seed
  function automatic logic [ID_W-1:0] lfsr_step(input logic [ID_W-1:0] v);
    return {v[4:0], v[5] ^ v[4]};
  endfunction

  // per-domain quota: floor of limit over count, zero when nothing is active
  function automatic int unsigned quota_of(input int unsigned lim, input int unsigned cnt);
    return (cnt == 0) ? 0 : lim / cnt;
  endfunction
endpackage

// File: rtl/vmq_divider.sv
module vmq_divider #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem;
  logic [W-1:0]  quo;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    trial;

  assign trial    = {rem[W-1:0], quo[W-1]};
  assign quotient = quo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= '0;
        quo <= dividend;
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        if (trial >= {1'b0, divisor}) begin
          rem <= trial - {1'b0, divisor};
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= trial;
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vmq_gid_gen.sv
module vmq_gid_gen
  import vmq_pkg::*;
#(
  parameter int SEED = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            clr_en,
  input  logic [ID_W-1:0] clr_id,
  input  logic [ID_W-1:0] query_id,
  output logic            in_use,
  output logic            found,
  output logic [ID_W-1:0] gid
);
  localparam int NIDS = 1 << ID_W;

  logic [NIDS-1:0] used;
  logic [ID_W-1:0] lfsr;
  logic            run;

  assign in_use = used[query_id];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used  <= '0;
      lfsr  <= ID_W'(SEED);
      run   <= 1'b0;
      found <= 1'b0;
      gid   <= '0;
    end else begin
      found <= 1'b0;
      lfsr  <= lfsr_step(lfsr);
      if (start) begin
        run <= 1'b1;
      end else if (run && !used[lfsr]) begin
        run        <= 1'b0;
        found      <= 1'b1;
        gid        <= lfsr;
        used[lfsr] <= 1'b1;
      end
      if (clr_en) used[clr_id] <= 1'b0;
    end
  end
endmodule

// File: rtl/vmq_sweep.sv
module vmq_sweep
  import vmq_pkg::*;
#(
  parameter int SEG_COUNT = 16,
  parameter int SEG_WORDS = 16,
  parameter int ADDR_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [ID_W-1:0]              victim,
  input  logic                         asg_en,
  input  logic [$clog2(SEG_COUNT)-1:0] asg_seg,
  input  logic [ID_W-1:0]              asg_id,
  input  logic [$clog2(SEG_COUNT)-1:0] rd_seg,
  output logic [ID_W-1:0]              rd_owner,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic                         done
);
  localparam int SIW = $clog2(SEG_COUNT);
  localparam int WW  = $clog2(SEG_WORDS);

  logic [ID_W-1:0] owner [SEG_COUNT];
  logic [ID_W-1:0] vic;
  logic [SIW-1:0]  seg;
  logic [WW-1:0]   word;
  logic            run;
  logic            hit;

  assign hit      = run && (owner[seg] == vic);
  assign mem_we   = hit;
  assign mem_addr = ADDR_W'({seg, word});
  assign rd_owner = owner[rd_seg];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_COUNT; i++) owner[i] <= '0;
      vic  <= '0;
      seg  <= '0;
      word <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run  <= 1'b1;
        vic  <= victim;
        seg  <= '0;
        word <= '0;
      end else if (run) begin
        if (hit && word != WW'(SEG_WORDS - 1)) begin
          word <= word + 1'b1;
        end else begin
          if (hit) owner[seg] <= '0;
          word <= '0;
          if (seg == SIW'(SEG_COUNT - 1)) begin
            run  <= 1'b0;
            done <= 1'b1;
          end else begin
            seg <= seg + 1'b1;
          end
        end
      end
      if (asg_en) owner[asg_seg] <= asg_id;
    end
  end
endmodule

// File: rtl/vm_quota_ctrl.sv
module vm_quota_ctrl
  import vmq_pkg::*;
#(
  parameter int MEM_WORDS  = 256,
  parameter int SEG_WORDS  = 16,
  parameter int MAX_ACTIVE = 8,
  parameter int DATA_W     = 32
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      boot,
  input  logic                                      launch_req,
  input  logic                                      halt_req,
  input  logic [5:0]                                halt_id,
  input  logic                                      asg_en,
  input  logic [$clog2(MEM_WORDS/SEG_WORDS)-1:0]    asg_seg,
  input  logic [5:0]                                asg_id,
  input  logic [$clog2(MEM_WORDS/SEG_WORDS)-1:0]    rd_seg,
  output logic [5:0]                                rd_owner,
  output logic [$clog2(MEM_WORDS/SEG_WORDS+1)-1:0]  seg_limit,
  output logic [$clog2(MEM_WORDS/SEG_WORDS+1)-1:0]  tot,
  output logic [$clog2(MEM_WORDS/SEG_WORDS+1)-1:0]  seg_max,
  output logic                                      busy,
  output logic                                      launch_ack,
  output logic [5:0]                                new_gid,
  output logic                                      launch_err,
  output logic                                      halt_done,
  output logic                                      halt_err,
  output logic                                      mem_we,
  output logic [$clog2(MEM_WORDS)-1:0]              mem_addr,
  output logic [DATA_W-1:0]                         mem_wdata
);
  localparam int SEG_COUNT = MEM_WORDS / SEG_WORDS;
  localparam int CNT_W     = $clog2(SEG_COUNT + 1);
  localparam int ADDR_W    = $clog2(MEM_WORDS);

  ctl_state_e      st;
  logic            div_go;
  logic [ID_W-1:0] vic_id;

  // named internal events
  logic            gid_start, gid_found, id_active;
  logic [ID_W-1:0] gid_val;
  logic            sweep_start, sweep_done;
  logic            div_done;
  logic [CNT_W-1:0] div_q;
  logic            launch_ok, halt_ok, asg_ok;

  assign busy        = (st == ST_GID) || (st == ST_SWEEP) || (st == ST_DIV);
  assign launch_ok   = tot < CNT_W'(MAX_ACTIVE);
  assign halt_ok     = (halt_id != '0) && (tot > CNT_W'(1)) && id_active;
  assign gid_start   = (st == ST_IDLE) && launch_req && launch_ok;
  assign sweep_start = (st == ST_IDLE) && !launch_req && halt_req && halt_ok;
  assign asg_ok      = asg_en && !busy;
  assign mem_wdata   = '0;

  vmq_gid_gen #(.SEED(1)) u_gid (
    .clk(clk), .rst_n(rst_n), .start(gid_start),
    .clr_en(sweep_done), .clr_id(vic_id), .query_id(halt_id),
    .in_use(id_active), .found(gid_found), .gid(gid_val)
  );

  vmq_sweep #(.SEG_COUNT(SEG_COUNT), .SEG_WORDS(SEG_WORDS), .ADDR_W(ADDR_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(sweep_start), .victim(halt_id),
    .asg_en(asg_ok), .asg_seg(asg_seg), .asg_id(asg_id),
    .rd_seg(rd_seg), .rd_owner(rd_owner),
    .mem_we(mem_we), .mem_addr(mem_addr), .done(sweep_done)
  );

  vmq_divider #(.W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_go),
    .dividend(seg_limit), .divisor(tot),
    .quotient(div_q), .done(div_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_OFF;
      tot        <= '0;
      seg_limit  <= '0;
      seg_max    <= '0;
      div_go     <= 1'b0;
      vic_id     <= '0;
      new_gid    <= '0;
      launch_ack <= 1'b0;
      launch_err <= 1'b0;
      halt_done  <= 1'b0;
      halt_err   <= 1'b0;
    end else begin
      div_go     <= 1'b0;
      launch_ack <= 1'b0;
      launch_err <= 1'b0;
      halt_done  <= 1'b0;
      halt_err   <= 1'b0;
      unique case (st)
        ST_OFF: if (boot) begin
          seg_limit <= CNT_W'(SEG_COUNT);
          tot       <= CNT_W'(1);
          div_go    <= 1'b1;
          st        <= ST_DIV;
        end
        ST_IDLE: begin
          if (launch_req) begin
            if (launch_ok) st <= ST_GID;
            else           launch_err <= 1'b1;
          end else if (halt_req) begin
            if (halt_ok) begin
              vic_id <= halt_id;
              st     <= ST_SWEEP;
            end else begin
              halt_err <= 1'b1;
            end
          end
        end
        ST_GID: if (gid_found) begin
          tot        <= tot + 1'b1;
          new_gid    <= gid_val;
          launch_ack <= 1'b1;
          div_go     <= 1'b1;
          st         <= ST_DIV;
        end
        ST_SWEEP: if (sweep_done) begin
          tot       <= tot - 1'b1;
          halt_done <= 1'b1;
          div_go    <= 1'b1;
          st        <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          seg_max <= div_q;
          st      <= ST_IDLE;
        end
        default: st <= ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/vmq_checker.sv
module vmq_checker
  import vmq_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [CNT_W-1:0]  tot,
  input logic [CNT_W-1:0]  seg_limit,
  input logic [CNT_W-1:0]  seg_max,
  input logic              launch_ack,
  input logic [ID_W-1:0]   new_gid,
  input logic              launch_err,
  input logic              halt_done,
  input logic              halt_err,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              div_done
);
  a_r1_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_limit != '0) |=> (seg_limit == $past(seg_limit)));

  a_r2_launch_step: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ack |-> (tot == CNT_W'($past(tot) + 1'b1)));

  a_r2_gid_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ack |-> (new_gid != '0));

  a_r3_halt_step: assert property (@(posedge clk) disable iff (!rst_n)
    halt_done |-> (tot == CNT_W'($past(tot) - 1'b1)));

  a_r4_quota_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (seg_max == CNT_W'(quota_of(seg_limit, tot))));

  a_r4_div_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> busy);

  a_r6_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r6_write_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  a_r7_halt_refused: assert property (@(posedge clk) disable iff (!rst_n)
    halt_err |-> ((tot == $past(tot)) && !busy));

  a_r8_launch_refused: assert property (@(posedge clk) disable iff (!rst_n)
    launch_err |-> ((tot == $past(tot)) && !busy));
endmodule

bind vm_quota_ctrl vmq_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tot(tot), .seg_limit(seg_limit),
  .seg_max(seg_max), .launch_ack(launch_ack), .new_gid(new_gid),
  .launch_err(launch_err), .halt_done(halt_done), .halt_err(halt_err),
  .mem_we(mem_we), .mem_addr(mem_addr), .div_done(div_done)
);

// File: tb/vm_quota_ctrl_bench.sv
module vm_quota_ctrl_bench;
  localparam int NSEG = 16;
  localparam int SW   = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic boot = 0, launch_req = 0, halt_req = 0, asg_en = 0;
  logic [5:0] halt_id = 0, asg_id = 0;
  logic [3:0] asg_seg = 0, rd_seg = 0;
  logic [5:0] rd_owner, new_gid;
  logic [4:0] seg_limit, tot, seg_max;
  logic busy, launch_ack, launch_err, halt_done, halt_err, mem_we;
  logic [7:0] mem_addr;
  logic [31:0] mem_wdata;

  always #2 clk = ~clk;

  vm_quota_ctrl u_vm_quota_ctrl (.*);

  int n_chk = 0, n_err = 0;
  int n_ack = 0, n_lerr = 0, n_done = 0, n_herr = 0, n_wr = 0, n_badwr = 0;
  int slot_gid [8];
  bit slot_on [8];
  int model_own [NSEG];
  int victim_m = -1;

  always @(posedge clk) begin
    if (launch_ack) n_ack++;
    if (launch_err) n_lerr++;
    if (halt_done)  n_done++;
    if (halt_err)   n_herr++;
    if (mem_we) begin
      n_wr++;
      if (model_own[mem_addr / SW] != victim_m || mem_wdata != 0) n_badwr++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    for (int i = 0; i < 600 && busy; i++) @(negedge clk);
  endtask

  task automatic launch_op(input int slot, input int etot);
    int a0 = n_ack;
    @(negedge clk) launch_req = 1;
    @(negedge clk) launch_req = 0;
    settle();
    chk(n_ack == a0 + 1, "R2 launch ack", n_ack - a0, 1);
    chk(new_gid != 0, "R2 gid nonzero", new_gid, 1);
    for (int k = 0; k < 8; k++)
      if (slot_on[k]) chk(slot_gid[k] != new_gid, "R2 gid distinct", new_gid, slot_gid[k]);
    slot_gid[slot] = new_gid; slot_on[slot] = 1;
    chk(tot == etot, "R2 tot", tot, etot);
    chk(seg_max == NSEG / etot, "R4 seg_max", seg_max, NSEG / etot);
  endtask

  task automatic halt_op(input int slot, input int etot);
    int d0 = n_done, w0 = n_wr, owned = 0, id = slot_gid[slot];
    for (int s = 0; s < NSEG; s++) if (model_own[s] == id) owned++;
    victim_m = id;
    @(negedge clk) begin halt_req = 1; halt_id = 6'(id); end
    @(negedge clk) halt_req = 0;
    settle();
    chk(n_done == d0 + 1, "R3 halt done", n_done - d0, 1);
    chk(tot == etot, "R3 tot", tot, etot);
    chk(seg_max == NSEG / etot, "R4 seg_max", seg_max, NSEG / etot);
    chk(n_wr - w0 == owned * SW, "R6 write count", n_wr - w0, owned * SW);
    chk(n_badwr == 0, "R6 write target", n_badwr, 0);
    for (int s = 0; s < NSEG; s++) begin
      rd_seg = 4'(s); #1;
      if (model_own[s] == id) model_own[s] = 0;
      chk(rd_owner == model_own[s], "R6 owner entry", rd_owner, model_own[s]);
    end
    slot_on[slot] = 0; victim_m = -1;
  endtask

  task automatic assign_op(input int seg, input int slot);
    @(negedge clk) begin asg_en = 1; asg_seg = 4'(seg); asg_id = 6'(slot_gid[slot]); end
    @(negedge clk) asg_en = 0;
    model_own[seg] = slot_gid[slot];
    rd_seg = 4'(seg); #1;
    chk(rd_owner == slot_gid[slot], "R9 owner write", rd_owner, slot_gid[slot]);
  endtask

  // op: 0 launch, 1 halt, 2 assign ; slot ; seg ; expected tot ; expected quota
  localparam logic [18:0] VEC [16] = '{
    {2'd0, 3'd0, 4'd0,  5'd2, 5'd8}, {2'd0, 3'd1, 4'd0,  5'd3, 5'd5},
    {2'd0, 3'd2, 4'd0,  5'd4, 5'd4}, {2'd2, 3'd1, 4'd3,  5'd0, 5'd0},
    {2'd2, 3'd1, 4'd5,  5'd0, 5'd0}, {2'd2, 3'd0, 4'd4,  5'd0, 5'd0},
    {2'd2, 3'd1, 4'd15, 5'd0, 5'd0}, {2'd1, 3'd1, 4'd0,  5'd3, 5'd5},
    {2'd0, 3'd1, 4'd0,  5'd4, 5'd4}, {2'd0, 3'd3, 4'd0,  5'd5, 5'd3},
    {2'd0, 3'd4, 4'd0,  5'd6, 5'd2}, {2'd0, 3'd5, 4'd0,  5'd7, 5'd2},
    {2'd0, 3'd6, 4'd0,  5'd8, 5'd2}, {2'd2, 3'd6, 4'd0,  5'd0, 5'd0},
    {2'd1, 3'd0, 4'd0,  5'd7, 5'd2}, {2'd1, 3'd6, 4'd0,  5'd6, 5'd2}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int a0, d0, h0, l0, spare;
    for (int s = 0; s < NSEG; s++) model_own[s] = 0;
    for (int k = 0; k < 8; k++) slot_on[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state and pre-boot requests
    chk(tot == 0 && seg_limit == 0 && seg_max == 0 && !busy, "R1 reset state", tot, 0);
    @(negedge clk) launch_req = 1;
    @(negedge clk) launch_req = 0;
    repeat (80) @(negedge clk);
    chk(n_ack == 0 && tot == 0, "R1 pre-boot launch ignored", n_ack, 0);
    // R1 boot
    @(negedge clk) boot = 1;
    @(negedge clk) boot = 0;
    chk(busy == 1, "R4 busy after boot", busy, 1);
    settle();
    chk(seg_limit == 16, "R1 seg_limit", seg_limit, 16);
    chk(tot == 1, "R1 tot", tot, 1);
    chk(seg_max == 16, "R4 boot quota", seg_max, 16);

    for (int v = 0; v < 16; v++) begin
      case (VEC[v][18:17])
        2'd0: launch_op(int'(VEC[v][16:14]), int'(VEC[v][9:5]));
        2'd1: halt_op(int'(VEC[v][16:14]), int'(VEC[v][9:5]));
        default: assign_op(int'(VEC[v][13:10]), int'(VEC[v][16:14]));
      endcase
      if (VEC[v][18:17] != 2'd2)
        chk(seg_max == VEC[v][4:0], "R4 vector quota", seg_max, VEC[v][4:0]);
    end

    // R8 launch at the active limit
    launch_op(0, 7);
    launch_op(6, 8);
    l0 = n_lerr;
    @(negedge clk) launch_req = 1;
    @(negedge clk) launch_req = 0;
    repeat (3) @(negedge clk);
    chk(n_lerr == l0 + 1, "R8 launch refused", n_lerr - l0, 1);
    chk(tot == 8, "R8 tot held", tot, 8);

    // R5 requests while busy are dropped
    for (int s = 0; s < NSEG; s++) if (model_own[s] == slot_gid[1]) model_own[s] = 0;
    assign_op(7, 1);
    a0 = n_ack; d0 = n_done;
    victim_m = slot_gid[1];
    @(negedge clk) begin halt_req = 1; halt_id = 6'(slot_gid[1]); end
    @(negedge clk) begin halt_req = 1; halt_id = 6'(slot_gid[2]); launch_req = 1; asg_en = 1; asg_seg = 4'd9; asg_id = 6'd5; end
    @(negedge clk) begin halt_req = 0; launch_req = 0; asg_en = 0; end
    settle();
    repeat (3) @(negedge clk);
    chk(n_done == d0 + 1, "R5 single halt served", n_done - d0, 1);
    chk(n_ack == a0, "R5 launch dropped", n_ack - a0, 0);
    chk(tot == 7, "R5 tot", tot, 7);
    rd_seg = 4'd9; #1;
    chk(rd_owner == 0, "R5 assign dropped", rd_owner, 0);
    rd_seg = 4'd7; #1;
    chk(rd_owner == 0, "R6 halted segment cleared", rd_owner, 0);
    model_own[7] = 0; slot_on[1] = 0; victim_m = -1;

    // R10 launch wins over a simultaneous halt
    a0 = n_ack; d0 = n_done;
    @(negedge clk) begin launch_req = 1; halt_req = 1; halt_id = 6'(slot_gid[2]); end
    @(negedge clk) begin launch_req = 0; halt_req = 0; end
    settle();
    chk(n_ack == a0 + 1, "R10 launch served", n_ack - a0, 1);
    chk(n_done == d0, "R10 halt dropped", n_done - d0, 0);
    chk(tot == 8, "R10 tot", tot, 8);
    slot_gid[1] = new_gid; slot_on[1] = 1;

    // R7 refused halts
    h0 = n_herr;
    @(negedge clk) begin halt_req = 1; halt_id = 6'd0; end
    @(negedge clk) halt_req = 0;
    repeat (2) @(negedge clk);
    chk(n_herr == h0 + 1, "R7 halt of id 0", n_herr - h0, 1);
    spare = 0;
    for (int g = 63; g > 0; g--) begin
      bit taken = 0;
      for (int k = 0; k < 8; k++) if (slot_on[k] && slot_gid[k] == g) taken = 1;
      if (!taken) spare = g;
    end
    @(negedge clk) begin halt_req = 1; halt_id = 6'(spare); end
    @(negedge clk) halt_req = 0;
    repeat (2) @(negedge clk);
    chk(n_herr == h0 + 2, "R7 halt of inactive id", n_herr - h0, 2);
    chk(tot == 8, "R7 tot held", tot, 8);

    // R1 second boot ignored
    @(negedge clk) boot = 1;
    @(negedge clk) boot = 0;
    chk(!busy && tot == 8 && seg_limit == 16, "R1 reboot ignored", tot, 8);

    // drain to one active domain, then R7 at the floor
    begin
      int t = 8;
      for (int k = 0; k < 8; k++) if (slot_on[k]) begin t--; halt_op(k, t); end
    end
    chk(tot == 1 && seg_max == 16, "R4 back to one", seg_max, 16);
    h0 = n_herr;
    @(negedge clk) begin halt_req = 1; halt_id = 6'(slot_gid[0]); end
    @(negedge clk) halt_req = 0;
    repeat (2) @(negedge clk);
    chk(n_herr == h0 + 1 && tot == 1, "R7 halt at floor", n_herr - h0, 1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule